// File: doc/BRIEF.md
# HDLC Bit-Stuffing Transmitter with Self-Clearing End-of-Message

The block turns bytes that a processor writes into a small transmit FIFO into a serial HDLC bit stream. While no frame is in progress it sends flag octets back to back. When the FIFO holds data at a flag boundary, a frame starts. The queued bytes go out least significant bit first with zero insertion. After the last byte comes a 16-bit frame check sequence and then a closing flag. The carrier supplies the transmit opportunities through a one-cycle bit-slot enable, so the serial output moves only in those slots.

Software closes a frame by setting an end-of-message bit. This marks the byte already at the tail of the FIFO as the last one. When the FIFO has drained, the FCS is sent and the bit clears itself. If the FIFO runs dry in the middle of a frame without that bit, the frame is aborted. A mode input selects which events raise the interrupt. A polarity input selects whether the interrupt pin is active high or active low.

Top module: `hdlc_eom_tx`

## Requirements
- R1: While no frame is in progress, the output repeats the flag octet 0x7E, sent least significant bit first (0,1,1,1,1,1,1,0).
- R2: `tx_bit` changes only on a clock edge where `bit_en` is 1, and it holds its value on every other edge.
- R3: At the end of a flag, if the FIFO is not empty, a frame starts in the next slot. Its bytes follow in write order, each sent least significant bit first.
- R4: After five consecutive ones in the data or FCS bits, a single 0 is inserted. This also applies when the fifth one is the last FCS bit. Flag and abort bits are never stuffed.
- R5: The FCS is the reflected CRC-16 (polynomial 0x8408 in shift-right form, preset 0xFFFF) over the data bits. Its complement is sent low byte first, each byte least significant bit first, and a flag follows.
- R6: A pulse on `eom_set` marks the byte last written as the final byte. A pulse that arrives in the same slot as the last data bit of that byte still ends the frame with an FCS.
- R7: `eom_flag` reads 1 from the `eom_set` pulse until the slot carrying the last FCS bit, and then returns to 0.
- R8: If the FIFO is empty when a data byte ends and end of message is not set, the frame is closed with the abort octet 0x7F (seven ones, then a 0) and flags resume.
- R9: With `half_irq_mode` at 1, the interrupt pulses when a byte is removed that takes the FIFO count from DEPTH/2+1 to DEPTH/2 with no write in the same cycle, and when the last FCS bit goes out. An abort raises no interrupt in this mode.
- R10: With `half_irq_mode` at 0, the interrupt pulses only when the last FCS bit goes out or when an abort starts.
- R11: Each interrupt is a one-cycle active pulse in the cycle after the event edge. The active level is 0 when `irq_active_low` is 1 and 1 otherwise, and the pin sits at the inactive level at all other times.
- R12: A write while the FIFO holds DEPTH bytes is dropped.
- R13: Synchronous reset gives `tx_bit` = 1, `eom_flag` = 0, `irq_pin` inactive, an empty FIFO, and flag transmission from the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Processor byte write strobe |
| wr_data | input | 8 | Byte to queue |
| eom_set | input | 1 | Pulse that sets the end-of-message bit |
| half_irq_mode | input | 1 | 1: interrupt on half-drain and completion; 0: completion and underflow |
| irq_active_low | input | 1 | 1: interrupt pin active low |
| bit_en | input | 1 | Transmit slot enable, one bit per asserted cycle |
| tx_bit | output | 1 | Serial HDLC output |
| eom_flag | output | 1 | Current end-of-message bit |
| irq_pin | output | 1 | Interrupt pulse at the selected polarity |

## Verification
The end-of-message pulse and the end-of-data decision can land in the same slot. The bench drives `eom_set` together with the `bit_en` that carries the last data bit and expects a normal FCS and flag rather than an abort. The bench also aims a half-drain removal at the first flag boundary and at later byte boundaries, and compares the interrupt slot by slot. Every slot of every frame is judged against a stream model in the bench. This model rebuilds flags, stuffing, CRC and interrupt positions from the requirements.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int          OCTET_W   = 8;
  localparam int          CRC_W     = 16;
  localparam logic [7:0]  FLAG_OCT  = 8'h7E;
  localparam logic [7:0]  ABORT_OCT = 8'h7F;
  localparam logic [15:0] CRC_POLY  = 16'h8408;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam int          STUFF_RUN = 5;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       step,
  input  logic       din,
  output logic [7:0] fcs_lo_next,
  output logic [7:0] fcs_hi
);
  logic [CRC_W-1:0] crc_q, crc_nx;

  always_comb begin
    crc_nx = crc_q >> 1;
    if (crc_q[0] ^ din) crc_nx = crc_nx ^ CRC_POLY;
  end

  assign fcs_lo_next = ~crc_nx[7:0];
  assign fcs_hi      = ~crc_q[15:8];

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= CRC_INIT;
    else if (step)   crc_q <= crc_nx;
  end
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_dout,
  input  logic       eom_now,
  input  logic [7:0] fcs_lo_next,
  input  logic [7:0] fcs_hi,
  output logic       pop_o,
  output logic       done_o,
  output logic       udr_o,
  output logic       crc_init_o,
  output logic       crc_step_o,
  output logic       crc_bit_o,
  output logic       tx_bit_o
);
  tx_state_e  st_q;
  logic [7:0] sh_q;
  logic [2:0] bcnt_q;
  logic [2:0] ones_q;
  logic       fcs_hi_q;
  logic       stuff, counted, cur_bit, slot_last;

  assign cur_bit   = sh_q[0];
  assign stuff     = (ones_q == 3'(STUFF_RUN));
  assign counted   = (st_q == ST_DATA) || (st_q == ST_FCS);
  assign slot_last = bit_en && !stuff && (bcnt_q == 3'd7);
  assign crc_bit_o = cur_bit;

  always_comb begin
    pop_o      = 1'b0;
    done_o     = 1'b0;
    udr_o      = 1'b0;
    crc_init_o = 1'b0;
    crc_step_o = bit_en && !stuff && (st_q == ST_DATA);
    if (slot_last) begin
      case (st_q)
        ST_FLAG: if (!fifo_empty) begin
          pop_o      = 1'b1;
          crc_init_o = 1'b1;
        end
        ST_DATA: begin
          if (!fifo_empty)  pop_o = 1'b1;
          else if (!eom_now) udr_o = 1'b1;
        end
        ST_FCS:  done_o = fcs_hi_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_FLAG;
      sh_q     <= FLAG_OCT;
      bcnt_q   <= '0;
      ones_q   <= '0;
      fcs_hi_q <= 1'b0;
      tx_bit_o <= 1'b1;
    end else if (bit_en) begin
      if (stuff) begin
        tx_bit_o <= 1'b0;
        ones_q   <= '0;
      end else begin
        tx_bit_o <= cur_bit;
        sh_q     <= sh_q >> 1;
        bcnt_q   <= bcnt_q + 1'b1;
        ones_q   <= (counted && cur_bit) ? ones_q + 1'b1 : '0;
        if (bcnt_q == 3'd7) begin
          case (st_q)
            ST_FLAG: begin
              if (!fifo_empty) begin
                st_q <= ST_DATA;
                sh_q <= fifo_dout;
              end else begin
                sh_q <= FLAG_OCT;
              end
            end
            ST_DATA: begin
              if (!fifo_empty) begin
                sh_q <= fifo_dout;
              end else if (eom_now) begin
                st_q     <= ST_FCS;
                sh_q     <= fcs_lo_next;
                fcs_hi_q <= 1'b0;
              end else begin
                st_q <= ST_ABORT;
                sh_q <= ABORT_OCT;
              end
            end
            ST_FCS: begin
              if (!fcs_hi_q) begin
                sh_q     <= fcs_hi;
                fcs_hi_q <= 1'b1;
              end else begin
                st_q <= ST_FLAG;
                sh_q <= FLAG_OCT;
              end
            end
            default: begin
              st_q <= ST_FLAG;
              sh_q <= FLAG_OCT;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_eom_tx.sv
module hdlc_eom_tx #(
  parameter int FIFO_DEPTH = 8,
  localparam int AW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CW   = AW + 1,
  localparam int HALF = FIFO_DEPTH / 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eom_set,
  input  logic       half_irq_mode,
  input  logic       irq_active_low,
  input  logic       bit_en,
  output logic       tx_bit,
  output logic       eom_flag,
  output logic       irq_pin
);
  logic [7:0]    fifo_dout;
  logic [CW-1:0] fifo_count;
  logic          fifo_empty, fifo_full;
  logic          pop, done_ev, udr_ev, half_ev;
  logic          crc_init, crc_step, crc_bit;
  logic [7:0]    fcs_lo_next, fcs_hi;
  logic          eom_q, eom_now, irq_ev;

  hdlc_tx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .pop(pop),
    .dout(fifo_dout), .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  hdlc_tx_crc u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .step(crc_step), .din(crc_bit),
    .fcs_lo_next(fcs_lo_next), .fcs_hi(fcs_hi)
  );

  hdlc_tx_engine u_eng (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fifo_empty(fifo_empty),
    .fifo_dout(fifo_dout), .eom_now(eom_now), .fcs_lo_next(fcs_lo_next),
    .fcs_hi(fcs_hi), .pop_o(pop), .done_o(done_ev), .udr_o(udr_ev),
    .crc_init_o(crc_init), .crc_step_o(crc_step), .crc_bit_o(crc_bit),
    .tx_bit_o(tx_bit)
  );

  // A pulse arriving in the deciding slot already counts.
  assign eom_now  = eom_q || eom_set;
  assign eom_flag = eom_q;

  // Drain to half: a removal with no accepted write in the same cycle.
  assign half_ev = pop && !(wr_en && !fifo_full) && (fifo_count == CW'(HALF + 1));
  assign irq_ev  = done_ev || (half_irq_mode ? half_ev : udr_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      eom_q   <= 1'b0;
      irq_pin <= irq_active_low;
    end else begin
      if (done_ev)      eom_q <= 1'b0;
      else if (eom_set) eom_q <= 1'b1;
      irq_pin <= irq_ev ^ irq_active_low;
    end
  end
endmodule

// File: rtl/hdlc_eom_tx_chk.sv
module hdlc_eom_tx_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          tx_bit,
  input logic          eom_flag,
  input logic          irq_pin,
  input logic          irq_active_low,
  input logic          half_irq_mode,
  input logic          done_ev,
  input logic          udr_ev,
  input logic [CW-1:0] fifo_count
);
  // R2
  a_r2_hold_without_slot: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit));
  // R7
  a_r7_eom_kept_until_done: assert property (@(posedge clk) disable iff (rst)
    (eom_flag && !done_ev) |=> eom_flag);
  // R8
  a_r8_abort_without_eom: assert property (@(posedge clk) disable iff (rst)
    udr_ev |-> !eom_flag);
  // R9
  a_r9_abort_quiet_in_half_mode: assert property (@(posedge clk) disable iff (rst)
    (udr_ev && half_irq_mode) |=> (irq_pin == $past(irq_active_low)));
  // R10
  a_r10_done_raises_irq: assert property (@(posedge clk) disable iff (rst)
    done_ev |=> (irq_pin != $past(irq_active_low)));
  // R12
  a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));
  // R13
  a_r13_reset_state: assert property (@(posedge clk)
    rst |=> (tx_bit && !eom_flag && fifo_count == '0));
endmodule

bind hdlc_eom_tx hdlc_eom_tx_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit), .eom_flag(eom_flag),
  .irq_pin(irq_pin), .irq_active_low(irq_active_low),
  .half_irq_mode(half_irq_mode), .done_ev(done_ev), .udr_ev(udr_ev),
  .fifo_count(fifo_count)
);

// File: tb/test_hdlc_eom_tx.sv
`timescale 1ns/1ps
module test_hdlc_eom_tx;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rst, wr_en, eom_set, half_irq_mode, irq_active_low, bit_en;
  logic [7:0] wr_data;
  logic tx_bit, eom_flag, irq_pin;

  int n_vec = 0;
  int n_err = 0;
  logic [7:0] dat [16];
  bit exp_b[$];
  bit exp_i[$];
  int m_ones;
  int last_slot;

  always #5 clk = ~clk;

  hdlc_eom_tx #(.FIFO_DEPTH(DEPTH)) i_hdlc_eom_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eom_set(eom_set),
    .half_irq_mode(half_irq_mode), .irq_active_low(irq_active_low),
    .bit_en(bit_en), .tx_bit(tx_bit), .eom_flag(eom_flag), .irq_pin(irq_pin)
  );

  task automatic check(string req, int act, int expv);
    n_vec++;
    if (act != expv) begin
      n_err++;
      $display("FIFO-TX FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic add(bit b, bit ev, bit cnt);
    exp_b.push_back(b);
    exp_i.push_back(ev);
    if (cnt) begin
      if (b) m_ones++; else m_ones = 0;
      if (m_ones == 5) begin // R4 zero insertion
        exp_b.push_back(1'b0);
        exp_i.push_back(1'b0);
        m_ones = 0;
      end
    end else m_ones = 0;
  endtask

  // Stream model: em 0 = no end of message (abort), otherwise FCS.
  task automatic build(int n, int em, bit mode);
    logic [15:0] crc = 16'hFFFF;
    logic [15:0] fcs;
    bit b, fb;
    exp_b.delete();
    exp_i.delete();
    m_ones = 0;
    for (int j = 0; j < 8; j++)
      add(8'h7E >> j, (j == 7) && mode && (n == HALF + 1), 1'b0);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) begin
        bit ev = 1'b0;
        b  = dat[k][j];
        fb = crc[0] ^ b;
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
        if (j == 7) begin
          if (k < n - 1) ev = mode && ((n - k - 1) == HALF + 1);
          else begin
            ev = (em == 0) && !mode;
            last_slot = exp_b.size() + 1;
          end
        end
        add(b, ev, 1'b1);
      end
    end
    if (em != 0) begin
      fcs = ~crc;
      for (int j = 0; j < 16; j++) add(fcs[j], j == 15, 1'b1);
    end else begin
      for (int j = 0; j < 8; j++) add(8'h7F >> j, 1'b0, 1'b0);
    end
    for (int r = 0; r < 2; r++)
      for (int j = 0; j < 8; j++) add(8'h7E >> j, 1'b0, 1'b0);
  endtask

  task automatic do_reset(bit pol);
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; eom_set = 1'b0; bit_en = 1'b0;
    irq_active_low = pol;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // em: 0 none, 1 pulse before transmission, 2 pulse in the last data slot
  task automatic run_frame(int nwr, int em, bit mode, bit pol, string tag);
    int n = (nwr > DEPTH) ? DEPTH : nwr;
    do_reset(pol);
    half_irq_mode = mode;
    for (int k = 0; k < nwr; k++) begin
      wr_en = 1'b1; wr_data = dat[k];
      @(negedge clk);
    end
    wr_en = 1'b0;
    if (em == 1) begin
      eom_set = 1'b1;
      @(negedge clk);
      eom_set = 1'b0;
      check("R7 eom set", eom_flag, 1);
    end
    build(n, em, mode);
    for (int s = 1; s <= exp_b.size(); s++) begin
      bit_en  = 1'b1;
      eom_set = (em == 2) && (s == last_slot);
      @(negedge clk);
      bit_en  = 1'b0;
      eom_set = 1'b0;
      check({tag, " bit"}, tx_bit, exp_b[s-1]);
      check("R11 irq slot", irq_pin, exp_i[s-1] ^ pol);
      @(negedge clk);
      check("R11 irq idle", irq_pin, pol);
    end
    check("R7 eom after frame", eom_flag, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("WATCHDOG FAIL timeout actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; eom_set = 1'b0;
    half_irq_mode = 1'b0; irq_active_low = 1'b0; bit_en = 1'b0;

    // R13 reset state for both polarities
    do_reset(1'b1);
    check("R13 tx_bit", tx_bit, 1);
    check("R13 eom_flag", eom_flag, 0);
    check("R13 irq inactive low", irq_pin, 1);
    do_reset(1'b0);
    check("R13 irq inactive high", irq_pin, 0);

    // R1 idle flags, R2 hold without slot
    for (int s = 0; s < 24; s++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      check("R1 idle flag", tx_bit, (8'h7E >> (s % 8)) & 1);
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        check("R2 hold", tx_bit, (8'h7E >> (s % 8)) & 1);
      end
    end

    // R3 R4 R5 stuffing-heavy frame, R9 half mode, active high
    dat[0] = 8'hFF; dat[1] = 8'h7E; dat[2] = 8'h3E; dat[3] = 8'h1F;
    dat[4] = 8'hF8; dat[5] = 8'h00;
    run_frame(6, 1, 1'b1, 1'b0, "R4");
    // R10 completion-only mode, R11 active low
    run_frame(6, 1, 1'b0, 1'b1, "R5");
    // R8 underflow abort, both modes
    run_frame(3, 0, 1'b0, 1'b0, "R8");
    run_frame(3, 0, 1'b1, 1'b1, "R8");
    // R6 end of message in the deciding slot
    run_frame(4, 2, 1'b0, 1'b0, "R6");
    run_frame(5, 2, 1'b1, 1'b1, "R6");
    // R12 overfill drops the ninth byte
    for (int k = 0; k < 9; k++) dat[k] = 8'(k * 29 + 5);
    run_frame(9, 1, 1'b1, 1'b0, "R12");

    // R3 R9 R10 sweep over lengths, modes and polarities
    for (int len = 1; len <= DEPTH; len++) begin
      for (int md = 0; md < 2; md++) begin
        for (int k = 0; k < len; k++) dat[k] = 8'(k * 61 + len * 29 + md * 128 + 8'h3F);
        run_frame(len, 1, md[0], len[0], "R3");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule